// File: doc/BRIEF.md
# Three-Format Instruction Length Decoder

This block sits between an instruction fetch unit and the issue stage of a small 16-bit-encoded processor. It accepts one 16-bit leading instruction word per transfer. It sorts the word into one of three encoding formats and pulls out the opcode, the register numbers and the short immediate. It also states how many bytes the whole instruction occupies (2, 4 or 6), so that the fetch side knows how many extension bytes follow. Opcodes that the machine does not define are flagged as illegal.

The decode itself is combinational and is followed by a single registered output slot. Both edges are valid/ready streams. A word is taken when `in_valid` and `in_ready` are both high at a rising clock edge. A held result stays on the outputs, unchanged, until `out_ready` is seen high with `out_valid`. `in_ready` is high whenever the slot is empty or is being emptied in the same cycle. The stage therefore runs at one word per cycle when the consumer never stalls, and a stall passes straight back to the producer with no lost or repeated word. Fetching the extension words, executing the instruction and accessing memory are left to other blocks.

Top module: `insn_len_decoder`

## Requirements
- R1: When bit 15 of the word is 0, the format code is 1, the opcode is bits 15:8, register A is bits 7:4, register B is bits 3:0 and the immediate is 0.
- R2: When bits 15:14 are 2'b10, the format code is 2, the opcode is bits 13:12 zero-extended to 8 bits (0 increment, 1 decrement, 2 read special register, 3 write special register), register A is bits 11:8, register B is 0, the immediate is bits 7:0, and all four opcodes are legal.
- R3: When bits 15:14 are 2'b11, the format code is 3, the opcode is bits 13:10 zero-extended to 8 bits, registers A and B and the immediate are 0, opcodes 0 to 9 are legal and 10 to 15 are illegal.
- R4: Format-1 opcodes 0x00, 0x16, 0x17, 0x18 and every value above 0x39 are illegal; all other format-1 opcodes are legal.
- R5: Format-1 opcodes 0x01, 0x03, 0x08, 0x09, 0x1A, 0x1B, 0x1D, 0x1F, 0x20, 0x22, 0x24 and 0x30 have a length of 6 (a 32-bit word follows).
- R6: Format-1 opcodes 0x0C, 0x0D, 0x36, 0x37, 0x38 and 0x39 have a length of 4 (a 16-bit offset follows).
- R7: Every other legal instruction, including format-1 opcode 0x0F and all legal format-2 and format-3 words, has a length of 2.
- R8: An illegal word always reports a length of 2.
- R9: A word accepted at a rising edge shows on the outputs, with `out_valid` high, right after that same edge.
- R10: While `out_valid` is high and `out_ready` is low, `in_ready` is low and every output field stays unchanged.
- R11: While reset is asserted and right after it is released, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Upstream has a word on `in_word` |
| in_ready | output | 1 | The decoder can take a word this cycle |
| in_word | input | 16 | Leading instruction word |
| out_valid | output | 1 | A decoded result is held on the outputs |
| out_ready | input | 1 | Downstream takes the held result this cycle |
| out_fmt | output | 2 | Format code: 1, 2 or 3 |
| out_opcode | output | 8 | Opcode, zero-extended for formats 2 and 3 |
| out_reg_a | output | 4 | First register field |
| out_reg_b | output | 4 | Second register field (format 1 only) |
| out_imm | output | 8 | Unsigned 8-bit immediate (format 2 only) |
| out_len | output | 3 | Total instruction length in bytes |
| out_illegal | output | 1 | Opcode is not defined |

## Verification
Every decoded field is due exactly one edge after the word is accepted: the bench drives a word half a cycle before an edge and checks all of that word's fields half a cycle after the edge, before it drives the next word. All 65,536 word values are streamed back to back with the consumer always ready, so each result is checked in the cycle after its own word. For back-pressure, the bench stalls the consumer and, on each stalled cycle, checks that the held result and a low `in_ready` persist. It then releases the stall and checks that the blocked word appears one edge later.

// File: rtl/ild_pkg.sv
package ild_pkg;

  localparam int WORD_W = 16;
  localparam int OPC_W  = 8;
  localparam int REG_W  = 4;
  localparam int IMM_W  = 8;
  localparam int LEN_W  = 3;

  // format-2 opcode field and format-3 opcode field widths
  localparam int F2_OPC_W = 2;
  localparam int F3_OPC_W = 4;

  // highest defined format-1 opcode, and the size of its lookup table
  localparam int F1_LAST_OP = 8'h39;
  localparam int F1_TAB_N   = 64;
  localparam int F1_IDX_W   = $clog2(F1_TAB_N);

  // highest defined format-3 opcode
  localparam int F3_LAST_OP = 9;

  // byte counts
  localparam logic [LEN_W-1:0] LEN_SHORT = 3'd2;
  localparam logic [LEN_W-1:0] LEN_OFFS  = 3'd4;
  localparam logic [LEN_W-1:0] LEN_WIDE  = 3'd6;

  typedef enum logic [1:0] {
    FMT_NONE  = 2'd0,
    FMT_ONE   = 2'd1,
    FMT_TWO   = 2'd2,
    FMT_THREE = 2'd3
  } fmt_e;

  typedef struct packed {
    fmt_e               fmt;
    logic [OPC_W-1:0]   opc;
    logic [REG_W-1:0]   ra;
    logic [REG_W-1:0]   rb;
    logic [IMM_W-1:0]   imm;
    logic [LEN_W-1:0]   len;
    logic               bad;
  } dec_t;

  // Length class of a format-1 opcode that lies inside the defined range.
  function automatic logic [LEN_W-1:0] f1_len_of(input int unsigned op);
    logic [LEN_W-1:0] r;
    r = LEN_SHORT;
    case (op)
      8'h01, 8'h03, 8'h08, 8'h09,
      8'h1A, 8'h1B, 8'h1D, 8'h1F,
      8'h20, 8'h22, 8'h24, 8'h30: r = LEN_WIDE;
      8'h0C, 8'h0D,
      8'h36, 8'h37, 8'h38, 8'h39: r = LEN_OFFS;
      default:                    r = LEN_SHORT;
    endcase
    return r;
  endfunction

  // Whether a format-1 opcode below the table size is defined.
  function automatic logic f1_known(input int unsigned op);
    logic k;
    k = 1'b1;
    if (op == 0) k = 1'b0;
    else if (op >= 8'h16 && op <= 8'h18) k = 1'b0;
    else if (op > F1_LAST_OP) k = 1'b0;
    return k;
  endfunction

endpackage

// File: rtl/ild_field_split.sv
module ild_field_split
  import ild_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output fmt_e              fmt_o,
  output logic [OPC_W-1:0]  opc_o,
  output logic [REG_W-1:0]  ra_o,
  output logic [REG_W-1:0]  rb_o,
  output logic [IMM_W-1:0]  imm_o
);

  localparam int TOP = WORD_W - 1;

  always_comb begin
    fmt_o = FMT_ONE;
    opc_o = '0;
    ra_o  = '0;
    rb_o  = '0;
    imm_o = '0;
    if (!word_i[TOP]) begin
      fmt_o = FMT_ONE;
      opc_o = word_i[TOP -: OPC_W];
      ra_o  = word_i[2*REG_W-1 -: REG_W];
      rb_o  = word_i[REG_W-1:0];
    end else if (!word_i[TOP-1]) begin
      fmt_o = FMT_TWO;
      opc_o = {{(OPC_W-F2_OPC_W){1'b0}}, word_i[TOP-2 -: F2_OPC_W]};
      ra_o  = word_i[TOP-2-F2_OPC_W -: REG_W];
      imm_o = word_i[IMM_W-1:0];
    end else begin
      fmt_o = FMT_THREE;
      opc_o = {{(OPC_W-F3_OPC_W){1'b0}}, word_i[TOP-2 -: F3_OPC_W]};
    end
  end

endmodule

// File: rtl/ild_len_class.sv
module ild_len_class
  import ild_pkg::*;
(
  input  fmt_e             fmt_i,
  input  logic [OPC_W-1:0] opc_i,
  output logic [LEN_W-1:0] len_o,
  output logic             bad_o
);

  // per-opcode tables for format 1, built at elaboration
  logic [LEN_W-1:0] len_tab [F1_TAB_N];
  logic             ok_tab  [F1_TAB_N];

  for (genvar i = 0; i < F1_TAB_N; i++) begin : g_tab
    assign len_tab[i] = f1_len_of(i);
    assign ok_tab[i]  = f1_known(i);
  end

  logic             in_tab;
  logic [F1_IDX_W-1:0] idx;
  logic             f1_ok;
  logic [LEN_W-1:0] f1_len;

  assign in_tab = (opc_i < OPC_W'(F1_TAB_N));
  assign idx    = opc_i[F1_IDX_W-1:0];
  assign f1_ok  = in_tab && ok_tab[idx];
  assign f1_len = len_tab[idx];

  always_comb begin
    bad_o = 1'b0;
    len_o = LEN_SHORT;
    unique case (fmt_i)
      FMT_ONE: begin
        bad_o = !f1_ok;
        len_o = f1_ok ? f1_len : LEN_SHORT;
      end
      FMT_TWO: begin
        bad_o = 1'b0;
        len_o = LEN_SHORT;
      end
      FMT_THREE: begin
        bad_o = (opc_i > OPC_W'(F3_LAST_OP));
        len_o = LEN_SHORT;
      end
      default: begin
        bad_o = 1'b1;
        len_o = LEN_SHORT;
      end
    endcase
  end

endmodule

// File: rtl/ild_out_slice.sv
module ild_out_slice #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);

  logic         full_q;
  logic [W-1:0] data_q;

  assign up_ready = !full_q || dn_ready;
  assign dn_valid = full_q;
  assign dn_data  = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (up_valid && up_ready) begin
      full_q <= 1'b1;
      data_q <= up_data;
    end else if (dn_ready) begin
      full_q <= 1'b0;
    end
  end

  assert_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_ready) |=> (dn_valid && dn_data == $past(up_data)));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data)));

  assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |-> !up_ready);

endmodule

// File: rtl/insn_len_decoder.sv
module insn_len_decoder
  import ild_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_fmt,
  output logic [OPC_W-1:0]  out_opcode,
  output logic [REG_W-1:0]  out_reg_a,
  output logic [REG_W-1:0]  out_reg_b,
  output logic [IMM_W-1:0]  out_imm,
  output logic [LEN_W-1:0]  out_len,
  output logic              out_illegal
);

  localparam int DW = $bits(dec_t);

  fmt_e             s_fmt;
  logic [OPC_W-1:0] s_opc;
  logic [REG_W-1:0] s_ra, s_rb;
  logic [IMM_W-1:0] s_imm;
  logic [LEN_W-1:0] s_len;
  logic             s_bad;

  ild_field_split u_split (
    .word_i (in_word),
    .fmt_o  (s_fmt),
    .opc_o  (s_opc),
    .ra_o   (s_ra),
    .rb_o   (s_rb),
    .imm_o  (s_imm)
  );

  ild_len_class u_class (
    .fmt_i (s_fmt),
    .opc_i (s_opc),
    .len_o (s_len),
    .bad_o (s_bad)
  );

  dec_t d_in, d_out;
  logic [DW-1:0] q_bits;

  always_comb begin
    d_in.fmt = s_fmt;
    d_in.opc = s_opc;
    d_in.ra  = s_ra;
    d_in.rb  = s_rb;
    d_in.imm = s_imm;
    d_in.len = s_len;
    d_in.bad = s_bad;
  end

  ild_out_slice #(.W(DW)) u_slice (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (d_in),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (q_bits)
  );

  assign d_out       = dec_t'(q_bits);
  assign out_fmt     = d_out.fmt;
  assign out_opcode  = d_out.opc;
  assign out_reg_a   = d_out.ra;
  assign out_reg_b   = d_out.rb;
  assign out_imm     = d_out.imm;
  assign out_len     = d_out.len;
  assign out_illegal = d_out.bad;

  assert_bad_short_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_len == LEN_SHORT));

  assert_len_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len == LEN_SHORT || out_len == LEN_OFFS || out_len == LEN_WIDE));

  assert_f3_noregs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fmt == 2'd3) |-> (out_reg_a == '0 && out_reg_b == '0 && out_imm == '0));

  assert_f2_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fmt == 2'd2) |-> (!out_illegal && out_len == LEN_SHORT));

  assert_zero_op_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fmt == 2'd1 && out_opcode == '0) |-> out_illegal);

  assert_fmt_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_fmt != 2'd0));

endmodule

// File: tb/insn_len_decoder_test.sv
module insn_len_decoder_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [1:0]  out_fmt;
  logic [7:0]  out_opcode;
  logic [3:0]  out_reg_a, out_reg_b;
  logic [7:0]  out_imm;
  logic [2:0]  out_len;
  logic        out_illegal;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  insn_len_decoder uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_fmt(out_fmt), .out_opcode(out_opcode),
    .out_reg_a(out_reg_a), .out_reg_b(out_reg_b), .out_imm(out_imm),
    .out_len(out_len), .out_illegal(out_illegal)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference model written from the requirement text.
  task automatic model(input logic [15:0] w,
                       output logic [1:0] f, output logic [7:0] op,
                       output logic [3:0] ra, output logic [3:0] rb,
                       output logic [7:0] im, output logic [2:0] ln,
                       output logic il);
    int o;
    ra = 0; rb = 0; im = 0; il = 0; ln = 2;
    if (w[15] == 1'b0) begin
      f = 1; o = w / 256; op = 8'(o);
      ra = 4'((w / 16) % 16); rb = 4'(w % 16);
      il = (o == 0) || (o >= 22 && o <= 24) || (o > 57);
      if (!il) begin
        if (o inside {1, 3, 8, 9, 26, 27, 29, 31, 32, 34, 36, 48}) ln = 6;
        else if (o inside {12, 13, 54, 55, 56, 57}) ln = 4;
      end
    end else if (w[14] == 1'b0) begin
      f = 2; op = 8'((w / 4096) % 4);
      ra = 4'((w / 256) % 16); im = 8'(w % 256);
    end else begin
      f = 3; o = (w / 1024) % 16; op = 8'(o);
      il = (o > 9);
    end
  endtask

  task automatic check_word(input logic [15:0] w);
    logic [1:0] f; logic [7:0] op; logic [3:0] ra, rb;
    logic [7:0] im; logic [2:0] ln; logic il;
    string rf, ri, rl;
    model(w, f, op, ra, rb, im, ln, il);
    rf = (f == 1) ? "R1" : (f == 2) ? "R2" : "R3";
    ri = (f == 1) ? "R4" : (f == 2) ? "R2" : "R3";
    if (il) rl = "R8";
    else if (ln == 6) rl = "R5";
    else if (ln == 4) rl = "R6";
    else rl = "R7";
    check(out_valid === 1'b1, "R9", "out_valid", int'(out_valid), 1);
    check({out_fmt, out_opcode, out_reg_a, out_reg_b, out_imm} === {f, op, ra, rb, im},
          rf, $sformatf("fields w=%h", w),
          int'({out_fmt, out_opcode, out_reg_a, out_reg_b, out_imm}),
          int'({f, op, ra, rb, im}));
    check(out_illegal === il, ri, $sformatf("illegal w=%h", w), int'(out_illegal), int'(il));
    check(out_len === ln, rl, $sformatf("len w=%h", w), int'(out_len), int'(ln));
  endtask

  initial begin : watchdog
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    // R11 reset state
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R11", "out_valid in reset", int'(out_valid), 0);
    check(in_ready === 1'b1, "R11", "in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R11", "out_valid after reset", int'(out_valid), 0);
    check(in_ready === 1'b1, "R11", "in_ready after reset", int'(in_ready), 1);

    // Exhaustive stream, consumer always ready (R1..R9)
    out_ready = 1'b1;
    in_valid  = 1'b1;
    in_word   = 16'h0000;
    for (int i = 1; i <= 65536; i++) begin
      @(negedge clk);
      check(in_ready === 1'b1, "R9", "in_ready while streaming", int'(in_ready), 1);
      check_word(16'(i - 1));
      if (i < 65536) in_word = 16'(i);
    end
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid === 1'b0, "R9", "out_valid drains", int'(out_valid), 0);

    // Back-pressure (R10): 0x0901 is a 6-byte format-1 word, 0x8A5C format 2
    in_word = 16'h0901; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    check_word(16'h0901);
    check(in_ready === 1'b0, "R10", "in_ready during stall", int'(in_ready), 0);
    in_word = 16'h8A5C;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check_word(16'h0901);
      check(in_ready === 1'b0, "R10", "in_ready held low", int'(in_ready), 0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    check_word(16'h8A5C);
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid === 1'b0, "R10", "slot empties after release", int'(out_valid), 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule